// File: doc/BRIEF.md
# Host Register and Memory Access Port for a Time Slot Switch

This block connects an 8-bit microprocessor bus to a time slot switch. It has a 6-bit address, an active-low chip select, an active-high data strobe, a read/write line (high means read) and an active-low transfer acknowledge. The block decodes each host access. An access goes either to one local 8-bit control register or to a 32-byte window into one of the switch's three memories. The switch memories are the data memory and the high and low bytes of the connection memory.

The control register selects the window. Its stream field supplies the upper three bits of an 8-bit stream/channel address, and the low five host address bits supply the channel. Its memory-select field picks the target memory. A split flag sends every read to the data memory, while writes still follow memory select. A processor-enable flag is exported to the switching core.

Memory accesses use a host slot that the core grants through `slot_ok`, so that they never collide with the core's own reads. The port holds its request until that slot arrives and only then acknowledges. Control register accesses take no memory cycle and are acknowledged one cycle after the access starts.

Top module: `tsi_host_port`

## Requirements
- R1: An access with address bit 5 = 0 reaches the control register whatever address bits 4:0 hold. A read returns all 8 stored bits. The register is 0 after reset.
- R2: A control register access asserts `ack_n` low in the cycle after the access is first seen (chip select low, strobe high), and it raises no memory request.
- R3: An access with address bit 5 = 1 issues a memory request whose `mem_addr` is {control bits 2:0, host address bits 4:0}. The stream is in bits 7:5 and the channel is in bits 4:0.
- R4: Control bits 4:3 select the memory and appear on `mem_tgt` with the same code: 01 = connection high, 10 = connection low, 11 = data memory. Code 00 selects nothing. An access with code 00 raises no request, is acknowledged as fast as a control access, and a read returns 0.
- R5: When control bit 7 (split) is 1, every memory read targets the data memory (`mem_tgt` = 11), and writes still use bits 4:3.
- R6: `proc_all` equals control bit 6. Control bit 5 is stored and read back, and it changes no memory request.
- R7: `mem_req` stays high with stable request fields until a cycle in which `slot_ok` is high. Exactly one grant (`mem_req` and `slot_ok` both high at a clock edge) happens per memory access. `ack_n` stays high while `mem_req` is high.
- R8: On a memory read, `mem_rdata` is taken in the cycle after the grant and shows on `rdata` while `ack_n` is low.
- R9: `ack_n` stays low while chip select stays low and the strobe stays high. It goes high in the cycle after either of them is released.
- R10: On a memory write, `mem_we` is 1 and `mem_wdata` carries the host data sampled when the access started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ds | input | 1 | Data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Host address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| ack_n | output | 1 | Transfer acknowledge, active low |
| slot_ok | input | 1 | Host memory slot available this cycle |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the grant |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_tgt | output | 2 | Target memory code |
| mem_addr | output | 8 | Stream/channel address |
| mem_wdata | output | 8 | Memory write data |
| proc_all | output | 1 | Processor-enable flag for the switching core |

## Verification
The bench goes after the address decode at bit 5. A design that let bits 4:0 matter would corrupt or miss the control register. It also checks split reads: a port that ignored the split flag would read a connection memory instead of the data memory. Memory-select code 00 is tested, where a wrong design would issue a spurious request or hang waiting for a slot. Long slot denials are tested too: an early acknowledge or a drifting request address would show up as a wrong grant record or as `ack_n` low while `mem_req` is still high. Held strobes check that `ack_n` neither drops before the release nor lingers after it.

// File: rtl/tsi_host_pkg.sv
package tsi_host_pkg;
    localparam int DATA_W  = 8;
    localparam int HADDR_W = 6;
    localparam int CH_W    = 5;
    localparam int ST_W    = 3;
    localparam int MADDR_W = ST_W + CH_W;

    typedef enum logic [1:0] {
        TGT_NONE = 2'b00,
        TGT_CHI  = 2'b01,
        TGT_CLO  = 2'b10,
        TGT_DAT  = 2'b11
    } tgt_e;

    typedef struct packed {
        logic            split;
        logic            proc_all;
        logic            spare;
        tgt_e            msel;
        logic [ST_W-1:0] stream;
    } ctl_t;

    typedef struct packed {
        logic               we;
        tgt_e               tgt;
        logic [MADDR_W-1:0] addr;
        logic [DATA_W-1:0]  wdata;
    } mreq_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_WAIT  = 2'b01,
        S_FETCH = 2'b10,
        S_ACK   = 2'b11
    } seq_e;

    function automatic tgt_e pick_tgt(input ctl_t c, input logic is_read);
        return (is_read && c.split) ? TGT_DAT : c.msel;
    endfunction
endpackage

// File: rtl/tsi_ctl_reg.sv
module tsi_ctl_reg
    import tsi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= ctl_t'(wdata);
    end

    a_r1_holds_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(q));
endmodule

// File: rtl/tsi_decode.sv
module tsi_decode
    import tsi_host_pkg::*;
(
    input  ctl_t               ctl,
    input  logic [HADDR_W-1:0] addr,
    input  logic               rw,
    input  logic [DATA_W-1:0]  wdata,
    output logic               is_ctl,
    output mreq_t              op
);
    localparam int SEL_BIT = HADDR_W - 1;

    always_comb begin
        is_ctl   = ~addr[SEL_BIT];
        op.we    = ~rw;
        op.tgt   = pick_tgt(ctl, rw);
        op.addr  = {ctl.stream, addr[CH_W-1:0]};
        op.wdata = wdata;
    end
endmodule

// File: rtl/tsi_seq.sv
module tsi_seq
    import tsi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ds,
    input  logic              is_ctl,
    input  mreq_t             op,
    input  ctl_t              ctl_q,
    input  logic              slot_ok,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              ctl_we,
    output logic              ack_n,
    output logic [DATA_W-1:0] rdata,
    output logic              mem_req,
    output mreq_t             mem_op
);
    seq_e st;
    logic start;

    assign start   = ~cs_n & ds;
    assign ctl_we  = (st == S_IDLE) & start & is_ctl & op.we;
    assign ack_n   = (st != S_ACK);
    assign mem_req = (st == S_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            rdata  <= '0;
            mem_op <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    if (is_ctl) begin
                        if (!op.we) rdata <= DATA_W'(ctl_q);
                        st <= S_ACK;
                    end else if (op.tgt == TGT_NONE) begin
                        if (!op.we) rdata <= '0;
                        st <= S_ACK;
                    end else begin
                        mem_op <= op;
                        st     <= S_WAIT;
                    end
                end
                S_WAIT:  if (slot_ok) st <= mem_op.we ? S_ACK : S_FETCH;
                S_FETCH: begin
                    rdata <= mem_rdata;
                    st    <= S_ACK;
                end
                S_ACK:   if (!start) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !slot_ok) |=> (mem_req && $stable(mem_op)));
    a_r7_no_early_ack: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ack_n);
    a_r9_ack_holds: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && start) |=> !ack_n);
    a_r9_ack_release: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !start) |=> ack_n);
    a_r2_ctl_fast: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && start && is_ctl) |=> (!ack_n && !mem_req));
endmodule

// File: rtl/tsi_host_port.sv
module tsi_host_port
    import tsi_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               ds,
    input  logic               rw,
    input  logic [HADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               ack_n,
    input  logic               slot_ok,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_tgt,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic               proc_all
);
    ctl_t  ctl;
    mreq_t op;
    mreq_t mem_op;
    logic  is_ctl;
    logic  ctl_we;

    tsi_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(wdata), .q(ctl)
    );

    tsi_decode u_dec (
        .ctl(ctl), .addr(addr), .rw(rw), .wdata(wdata),
        .is_ctl(is_ctl), .op(op)
    );

    tsi_seq u_seq (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ds(ds), .is_ctl(is_ctl),
        .op(op), .ctl_q(ctl), .slot_ok(slot_ok), .mem_rdata(mem_rdata),
        .ctl_we(ctl_we), .ack_n(ack_n), .rdata(rdata),
        .mem_req(mem_req), .mem_op(mem_op)
    );

    assign mem_we    = mem_op.we;
    assign mem_tgt   = mem_op.tgt;
    assign mem_addr  = mem_op.addr;
    assign mem_wdata = mem_op.wdata;
    assign proc_all  = ctl.proc_all;

    a_r5_split_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && ctl.split) |-> (mem_tgt == TGT_DAT));
    a_r4_no_null_req: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_tgt != TGT_NONE));
endmodule

// File: tb/tb_tsi_host_port.sv
module tb_tsi_host_port;
    logic       clk = 0, rst = 1;
    logic       cs_n = 1, ds = 0, rw = 1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0, rdata, mem_rdata;
    logic       ack_n, slot_ok = 0, mem_req, mem_we, proc_all;
    logic [1:0] mem_tgt;
    logic [7:0] mem_addr, mem_wdata;

    tsi_host_port dut (.*);

    always #5 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    bit hold_slot = 0;

    logic [7:0] mem [4][256];
    logic [7:0] rd_q = '0;
    int         grants = 0;
    logic       g_we;
    logic [1:0] g_tgt;
    logic [7:0] g_addr, g_wdata;
    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && slot_ok) begin
            grants <= grants + 1;
            g_we <= mem_we; g_tgt <= mem_tgt; g_addr <= mem_addr; g_wdata <= mem_wdata;
            if (mem_we) mem[mem_tgt][mem_addr] <= mem_wdata;
            else        rd_q <= mem[mem_tgt][mem_addr];
        end
    end

    always @(negedge clk) slot_ok <= hold_slot ? 1'b0 : (($urandom % 3) == 0);

    always @(negedge clk) if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one host access; returns read data, cycles to ack and grant count
    task automatic access(input logic rd, input logic [5:0] a, input logic [7:0] wd,
                          input int hold, output logic [7:0] rv, output int lat, output int ng);
        int g0;
        g0 = grants;
        @(negedge clk);
        cs_n = 0; ds = 1; rw = rd; addr = a; wdata = wd;
        lat = 0;
        forever begin
            @(negedge clk); lat++;
            if (!ack_n || lat > 500) break;
        end
        rv = rdata;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(!ack_n, "R9 ack held", ack_n, 0);
        end
        ds = 0;
        @(negedge clk);
        chk(ack_n, "R9 ack release", ack_n, 1);
        cs_n = 1;
        ng = grants - g0;
    endtask

    logic [7:0] cr_m;
    task automatic set_cr(input logic [7:0] v);
        logic [7:0] rv; int lat, ng;
        access(0, {1'b0, 5'($urandom)}, v, 0, rv, lat, ng);
        cr_m = v;
        chk(lat == 1, "R2 ctl write latency", lat, 1);
        chk(ng == 0, "R2 ctl write no grant", ng, 0);
    endtask

    // memory access with expectations derived from the bench's own control copy
    task automatic mem_acc(input logic rd, input logic [4:0] ch, input logic [7:0] wd, input int hold);
        logic [1:0] et; logic [7:0] ea, ev, rv; int lat, ng;
        et = (rd && cr_m[7]) ? 2'b11 : cr_m[4:3];
        ea = {cr_m[2:0], ch};
        ev = (et == 2'b00) ? 8'h00 : mem[et][ea];
        access(rd, {1'b1, ch}, wd, hold, rv, lat, ng);
        if (et == 2'b00) begin
            chk(ng == 0, "R4 none no grant", ng, 0);
            chk(lat == 1, "R4 none fast ack", lat, 1);
            if (rd) chk(rv == 8'h00, "R4 none reads 0", rv, 0);
        end else begin
            chk(ng == 1, "R7 one grant", ng, 1);
            chk(g_tgt == et, rd && cr_m[7] ? "R5 split target" : "R4 target", g_tgt, et);
            chk(g_addr == ea, "R3 stream/channel address", g_addr, ea);
            chk(g_we == !rd, "R10 write enable", g_we, !rd);
            if (rd) chk(rv == ev, "R8 read data", rv, ev);
            else    chk(g_wdata == wd, "R10 write data", g_wdata, wd);
        end
    endtask

    initial begin
        logic [7:0] rv; int lat, ng;
        void'($urandom(32'd4242));
        for (int t = 0; t < 4; t++)
            for (int i = 0; i < 256; i++) mem[t][i] = 8'(i * 7 + t * 61 + 3);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ack_n, "R9 reset ack", ack_n, 1);
        chk(!mem_req, "R7 reset no req", mem_req, 0);
        chk(!proc_all, "R6 reset flag", proc_all, 0);
        access(1, 6'h15, 0, 0, rv, lat, ng);
        chk(rv == 0, "R1 reset register", rv, 0);
        chk(lat == 1 && ng == 0, "R2 ctl read fast", lat, 1);

        set_cr(8'hA5);
        access(1, 6'h1F, 0, 2, rv, lat, ng);
        chk(rv == 8'hA5, "R1 readback with bit5", rv, 8'hA5);
        chk(!proc_all, "R6 flag low", proc_all, 0);
        set_cr(8'h4E);
        chk(proc_all, "R6 flag high", proc_all, 1);

        // bit 5 must not move a request
        set_cr(8'h0B); mem_acc(0, 5'd9, 8'h3C, 0);
        set_cr(8'h2B); mem_acc(0, 5'd9, 8'hC3, 0);
        chk(g_addr == 8'h69 && g_tgt == 2'b01, "R6 spare bit no effect", g_addr, 8'h69);

        // select code 00
        set_cr(8'h05); mem_acc(1, 5'd3, 0, 0); mem_acc(0, 5'd4, 8'h11, 0);
        // split
        set_cr(8'h8A); mem_acc(1, 5'd31, 0, 0); mem_acc(0, 5'd0, 8'h77, 0);
        set_cr(8'h80); mem_acc(1, 5'd1, 0, 0);

        // slot denied for a long time
        set_cr(8'h17);
        hold_slot = 1;
        @(negedge clk);
        cs_n = 0; ds = 1; rw = 1; addr = 6'h2A;
        repeat (12) begin
            @(negedge clk);
            chk(mem_req && ack_n, "R7 wait for slot", {mem_req, ack_n}, 3);
            chk(mem_addr == 8'hEA, "R7 address stable", mem_addr, 8'hEA);
        end
        hold_slot = 0;
        for (int i = 0; i < 300 && ack_n; i++) @(negedge clk);
        chk(rdata == mem[2][8'hEA], "R8 read after long wait", rdata, mem[2][8'hEA]);
        ds = 0; @(negedge clk); cs_n = 1;
        chk(ack_n, "R9 release after wait", ack_n, 1);

        // random mix
        for (int k = 0; k < 80; k++) begin
            if (($urandom % 4) == 0) set_cr(8'($urandom));
            mem_acc(1'($urandom), 5'($urandom), 8'($urandom), int'($urandom % 3));
        end
        access(1, 6'h00, 0, 0, rv, lat, ng);
        chk(rv == cr_m, "R1 final readback", rv, cr_m);
        chk(proc_all == cr_m[6], "R6 final flag", proc_all, cr_m[6]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule